// File: doc/BRIEF.md
# Frame-Rate Tick Interrupt Unit

This block produces two periodic interrupt flags from video timing signals. Together they give system software a 100 Hz time base. The first flag is the clock tick. It is raised a fixed number of microseconds after the vertical sync pulse ends, counted on a 1 us strobe. The second flag is the end-of-picture event. It is raised on the first horizontal sync falling edge after the last active display line. Each event recurs once per field, so each fires at 50 Hz. The two are about half a field apart.

Both flags sit in a status byte. A flag stays set until software clears it by writing a one to its bit in a clear register. An enable mask selects which pending flags drive the interrupt line. Software reads the status byte after the line asserts to learn the cause. Bit 7 of that byte repeats the combined interrupt condition.

The video timing generator is not part of this block. Neither are the other interrupt sources that share the status byte.

Top module: `frame_tick_irq`

## Requirements
- R1: After reset, the status byte reads 0x00, `irq` is low, and the enable mask is clear. A pending flag therefore raises no interrupt until the mask is written.
- R2: Status bit 3 (clock tick) sets in the cycle after the `DELAY_US`-th `us_tick` that follows a `vsync_in` falling edge. The default is 8192 ticks. After `DELAY_US`-1 ticks the bit is still clear.
- R3: The delay timer fires once per vsync falling edge. If the clock-tick flag is cleared, further ticks do not set it again until the next vsync falling edge.
- R4: Status bit 2 (end of picture) sets in the cycle after the first `hsync_in` falling edge sampled while `last_line_in` is low, once `last_line_in` has been high. Hsync falling edges while `last_line_in` is high do not set it.
- R5: A write with `clr_we` high clears status bit 3 when `clr_data` bit 5 is 1, and clears status bit 2 when `clr_data` bit 4 is 1. Zeros in those positions, and every other bit of `clr_data`, have no effect.
- R6: If a flag is set and cleared in the same cycle, the flag ends up set.
- R7: A write with `mask_we` high loads the enable mask. `mask_data` bit 3 enables the clock tick and bit 2 enables end of picture. `irq` is high exactly when some enabled flag is pending, and status bit 7 equals `irq`.
- R8: A pending flag whose enable is clear still reads as 1 in the status byte, but it does not raise `irq`.
- R9: A new vsync falling edge that arrives while the delay is being counted restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle strobe each microsecond |
| vsync_in | input | 1 | Vertical sync, high during the pulse |
| hsync_in | input | 1 | Horizontal sync, high during the pulse |
| last_line_in | input | 1 | High during the last active display line |
| clr_we | input | 1 | Clear register write strobe |
| clr_data | input | 8 | Clear register write data (bit 5 clock tick, bit 4 end of picture) |
| mask_we | input | 1 | Enable mask write strobe |
| mask_data | input | 8 | Enable mask data (bit 3 clock tick, bit 2 end of picture) |
| status | output | 8 | Bit 7 interrupt, bit 3 clock tick, bit 2 end of picture, others 0 |
| irq | output | 1 | Interrupt request, active high |

## Verification
Some properties are checked on every cycle by assertions:
- the flag update rules: set beats clear, a clear takes effect, and a flag holds otherwise;
- the delay counter stays below its limit, disarms when it fires, and rearms at zero on every vsync falling edge;
- end of picture never fires during the last line;
- an asserted interrupt always has a pending flag behind it.

Other behaviour only the bench scenarios can show:
- the exact tick count before the clock flag appears;
- that a restarted count hides the earlier edge;
- that an ignored hsync edge or a zero clear bit really left the status byte unchanged.

// File: rtl/ftick_pkg.sv
package ftick_pkg;

  // Status byte layout
  localparam int ST_ANY_BIT = 7;
  localparam int ST_RTC_BIT = 3;
  localparam int ST_END_BIT = 2;

  // Clear register layout
  localparam int CL_RTC_BIT = 5;
  localparam int CL_END_BIT = 4;

  // Enable mask layout (same positions as the status flags)
  localparam int EN_RTC_BIT = ST_RTC_BIT;
  localparam int EN_END_BIT = ST_END_BIT;

  typedef struct packed {
    logic rtc;
    logic pic_end;
  } src_t;

  // Set has priority over clear.
  function automatic logic flag_next(input logic cur, input logic set_ev,
                                     input logic clr_ev);
    return set_ev | (cur & ~clr_ev);
  endfunction

  // Any flag that is both pending and enabled.
  function automatic logic any_enabled(input src_t pend, input src_t en);
    return (pend.rtc & en.rtc) | (pend.pic_end & en.pic_end);
  endfunction

  // Terminal count of the delay timer: the tick that completes the delay.
  function automatic logic delay_done(input int unsigned cnt,
                                      input int unsigned limit);
    return (cnt + 1) == limit;
  endfunction

endpackage

// File: rtl/ftick_edge.sv
module ftick_edge #(
  parameter bit FALLING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_in;
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = prev_q & ~sig_in;
    end else begin : g_rise
      assign edge_o = ~prev_q & sig_in;
    end
  endgenerate

endmodule

// File: rtl/ftick_delay.sv
module ftick_delay
  import ftick_pkg::*;
#(
  parameter int DELAY_US = 8192,
  parameter int CNT_W    = (DELAY_US > 2) ? $clog2(DELAY_US) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_i,
  output logic fire_o,
  output logic armed_o
);
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end  = delay_done(int'(unsigned'(cnt_q)), DELAY_US);
  assign fire_o  = armed_q & tick_i & at_end & ~start_i;
  assign armed_o = armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (start_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q && tick_i) begin
      if (at_end) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (int'(unsigned'(cnt_q)) < DELAY_US)); // R2
  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !armed_q); // R3
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !fire_o); // R3
  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (armed_q && cnt_q == '0)); // R9

endmodule

// File: rtl/ftick_lineend.sv
module ftick_lineend (
  input  logic clk,
  input  logic rst_n,
  input  logic last_line_i,
  input  logic hsync_fall_i,
  output logic fire_o
);
  logic seen_q;

  assign fire_o = seen_q & ~last_line_i & hsync_fall_i;

  always_ff @(posedge clk) begin
    if (!rst_n)           seen_q <= 1'b0;
    else if (last_line_i) seen_q <= 1'b1;
    else if (fire_o)      seen_q <= 1'b0;
  end

  AST_NO_FIRE_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    last_line_i |-> !fire_o); // R4
  AST_ONE_PER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !seen_q || last_line_i); // R4

endmodule

// File: rtl/ftick_flags.sv
module ftick_flags
  import ftick_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  src_t              set_i,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] clr_data,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] mask_data,
  output src_t              flags_o,
  output src_t              mask_o
);
  src_t flags_q, mask_q, clr_hit;

  assign clr_hit.rtc     = clr_we & clr_data[CL_RTC_BIT];
  assign clr_hit.pic_end = clr_we & clr_data[CL_END_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      flags_q.rtc     <= flag_next(flags_q.rtc, set_i.rtc, clr_hit.rtc);
      flags_q.pic_end <= flag_next(flags_q.pic_end, set_i.pic_end, clr_hit.pic_end);
      if (mask_we) begin
        mask_q.rtc     <= mask_data[EN_RTC_BIT];
        mask_q.pic_end <= mask_data[EN_END_BIT];
      end
    end
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;

  logic unused_wr_bits;
  assign unused_wr_bits = ^{clr_data[DATA_W-1:CL_RTC_BIT+1], clr_data[CL_END_BIT-1:0],
                            mask_data[DATA_W-1:EN_RTC_BIT+1], mask_data[EN_END_BIT-1:0]};

  AST_SET_WINS_RTC: assert property (@(posedge clk) disable iff (!rst_n)
    set_i.rtc |=> flags_q.rtc); // R6
  AST_SET_WINS_END: assert property (@(posedge clk) disable iff (!rst_n)
    set_i.pic_end |=> flags_q.pic_end); // R6
  AST_CLR_RTC: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit.rtc && !set_i.rtc) |=> !flags_q.rtc); // R5
  AST_CLR_END: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit.pic_end && !set_i.pic_end) |=> !flags_q.pic_end); // R5
  AST_HOLD_RTC: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_hit.rtc && !set_i.rtc) |=> $stable(flags_q.rtc)); // R5
  AST_HOLD_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_hit.pic_end && !set_i.pic_end) |=> $stable(flags_q.pic_end)); // R5
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q)); // R7

endmodule

// File: rtl/frame_tick_irq.sv
module frame_tick_irq
  import ftick_pkg::*;
#(
  parameter int DELAY_US = 8192,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              vsync_in,
  input  logic              hsync_in,
  input  logic              last_line_in,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] clr_data,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] mask_data,
  output logic [DATA_W-1:0] status,
  output logic              irq
);
  // Internal events brought out as named wires
  logic vsync_fall, hsync_fall;
  logic rtc_fire, end_fire, rtc_armed;
  src_t set_ev, flags, mask;

  ftick_edge #(.FALLING(1'b1)) u_vs_edge (
    .clk(clk), .rst_n(rst_n), .sig_in(vsync_in), .edge_o(vsync_fall));

  ftick_edge #(.FALLING(1'b1)) u_hs_edge (
    .clk(clk), .rst_n(rst_n), .sig_in(hsync_in), .edge_o(hsync_fall));

  ftick_delay #(.DELAY_US(DELAY_US)) u_delay (
    .clk(clk), .rst_n(rst_n), .start_i(vsync_fall), .tick_i(us_tick),
    .fire_o(rtc_fire), .armed_o(rtc_armed));

  ftick_lineend u_lineend (
    .clk(clk), .rst_n(rst_n), .last_line_i(last_line_in),
    .hsync_fall_i(hsync_fall), .fire_o(end_fire));

  assign set_ev.rtc     = rtc_fire;
  assign set_ev.pic_end = end_fire;

  ftick_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_ev), .clr_we(clr_we),
    .clr_data(clr_data), .mask_we(mask_we), .mask_data(mask_data),
    .flags_o(flags), .mask_o(mask));

  assign irq = any_enabled(flags, mask);

  always_comb begin
    status             = '0;
    status[ST_ANY_BIT] = irq;
    status[ST_RTC_BIT] = flags.rtc;
    status[ST_END_BIT] = flags.pic_end;
  end

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags.rtc || flags.pic_end)); // R7
  AST_RTC_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_fire |-> rtc_armed); // R3
  AST_RTC_ONLY_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags.rtc) |-> $past(rtc_fire)); // R2

endmodule

// File: tb/tb_frame_tick_irq.sv
module tb_frame_tick_irq;
  localparam int CLK_PERIOD = 10;
  localparam int DELAY      = 8192;

  logic clk = 1'b0, rst_n = 1'b0;
  logic us_tick = 0, vsync_in = 0, hsync_in = 0, last_line_in = 0;
  logic clr_we = 0, mask_we = 0;
  logic [7:0] clr_data = 0, mask_data = 0;
  logic [7:0] status;
  logic irq;

  frame_tick_irq #(.DELAY_US(DELAY)) dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .vsync_in(vsync_in),
    .hsync_in(hsync_in), .last_line_in(last_line_in), .clr_we(clr_we),
    .clr_data(clr_data), .mask_we(mask_we), .mask_data(mask_data),
    .status(status), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct {
    int         cyc;
    logic [7:0] st;
    string      tag;
  } item_t;
  item_t sb[$];

  // bench model
  logic m_rtc = 0, m_end = 0, m_en_rtc = 0, m_en_end = 0;

  function automatic logic [7:0] model_status();
    logic [7:0] s;
    logic       any;
    any  = (m_rtc && m_en_rtc) || (m_end && m_en_end);
    s    = 8'h00;
    if (any)   s = s | 8'h80;
    if (m_rtc) s = s | 8'h08;
    if (m_end) s = s | 8'h04;
    return s;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_now(input string tag);
    item_t it;
    it.cyc = cyc; it.st = model_status(); it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (it.cyc < cyc) begin
        failures++;
        $display("FAIL %s: check missed (cycle %0d, now %0d)", it.tag, it.cyc, cyc);
      end else if (status !== it.st || irq !== it.st[7]) begin
        failures++;
        $display("FAIL %s: status=%02h irq=%b expected status=%02h irq=%b",
                 it.tag, status, irq, it.st, it.st[7]);
      end
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      us_tick = 1; step();
      us_tick = 0; step();
    end
  endtask

  task automatic vsync_pulse(input int len);
    vsync_in = 1; repeat (len) step();
    vsync_in = 0; step();
  endtask

  task automatic hs_pulse();
    hsync_in = 1; step();
    hsync_in = 0; step();
  endtask

  task automatic write_clr(input logic [7:0] d);
    clr_we = 1; clr_data = d; step();
    clr_we = 0; clr_data = 0;
  endtask

  task automatic write_mask(input logic [7:0] d);
    mask_we = 1; mask_data = d; step();
    mask_we = 0; mask_data = 0;
    m_en_rtc = d[3]; m_en_end = d[2];
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    expect_now("R1 reset state");

    // R4: edges inside the last line are ignored; R8 and R1: mask clear
    last_line_in = 1; step();
    hs_pulse(); hs_pulse();
    expect_now("R4 hsync fall during last line ignored");
    last_line_in = 0; step(); step();
    expect_now("R4 no set before hsync edge");
    hs_pulse();
    m_end = 1; expect_now("R4/R8 end of picture pending, masked (R1 mask reset)");

    // R7: enable both
    write_mask(8'h0C);
    expect_now("R7 irq from enabled end-of-picture");

    // R5: zeros in clear positions have no effect
    write_clr(8'hCF);
    expect_now("R5 clear with bits 5/4 zero ignored");
    write_clr(8'h20);
    expect_now("R5 clock-tick clear leaves end-of-picture");
    write_clr(8'h10);
    m_end = 0; expect_now("R5 bit 4 clears end of picture");

    // R2: exact delay
    vsync_pulse(160);
    ticks(DELAY - 1);
    expect_now("R2 not set one tick early");
    ticks(1);
    m_rtc = 1; expect_now("R2 clock tick set after full delay");

    // R3: no refire without new vsync edge
    write_clr(8'h20);
    m_rtc = 0; expect_now("R5 bit 5 clears clock tick");
    ticks(300);
    expect_now("R3 no second fire");

    // R9: restart on new edge
    vsync_pulse(20);
    ticks(4000);
    vsync_pulse(20);
    ticks(DELAY - 1);
    expect_now("R9 restarted count not yet done");
    ticks(1);
    m_rtc = 1; expect_now("R9 fires after restarted delay");
    write_clr(8'h20); m_rtc = 0;

    // R6: set and clear in the same cycle
    vsync_pulse(10);
    ticks(DELAY - 1);
    us_tick = 1; clr_we = 1; clr_data = 8'h20; step();
    us_tick = 0; clr_we = 0; clr_data = 0;
    m_rtc = 1; expect_now("R6 clock-tick set beats clear");
    last_line_in = 1; step(); last_line_in = 0; step();
    hsync_in = 1; step();
    hsync_in = 0; clr_we = 1; clr_data = 8'h10; step();
    clr_we = 0; clr_data = 0;
    m_end = 1; expect_now("R6 end-of-picture set beats clear");

    // R7/R8: enable only the clock tick
    write_mask(8'h08);
    write_clr(8'h20); m_rtc = 0;
    expect_now("R8 masked end-of-picture gives no irq");
    write_mask(8'h04);
    expect_now("R7 re-enable end-of-picture raises irq");

    step(); step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule